// File: doc/BRIEF.md
# Cascadable Serial Command Front End for an LED Display Driver

This block receives 16-bit command words over a three-wire serial link (serial clock, data in, load strobe) and turns them into register writes for a multi-digit LED display driver. Each word carries a 4-bit register address and an 8-bit data value. The word also leaves the block again on a data-out pin, delayed by one full word, so several devices can share the serial clock and load strobe and be daisy-chained data-out to data-in. When the load strobe rises, every device in the chain decodes whatever word its own shift register holds at that moment. A device that holds a no-op word leaves its registers alone. To address the Nth device, the host therefore sends the real command first and then N-1 no-op words.

The register file holds eight digit registers, four control registers, a display-test bit and a 2-bit mode register. The mode register carries the external-clock select and the soft-reset request. A soft reset returns everything except the mode register to its default state and holds it there until the request bit is cleared. The display-test bit forces the display on without disturbing any stored setting. The serial pins are oversampled by the system clock, so the whole block runs in one clock domain.

Top module: `led_cmd_frontend`

## Requirements
- R1: After the hardware reset, all digit and control outputs, test_mode, soft_reset, ext_clk_sel, wr_strobe and ser_dout are 0.
- R2: A word is shifted in MSB first on rising edges of ser_clk. Bits 11..8 are the address, bits 7..0 the data, and bits 15..12 are ignored. On a rising edge of ser_load, address k in 1..8 stores the data in digit_flat[8*(k-1)+:8].
- R3: On a load, address k in 9..12 stores the data in ctrl_flat[8*(k-9)+:8].
- R4: A loaded word with address 0 (no-op) changes no register and produces no wr_strobe.
- R5: ser_dout changes only after a falling edge of ser_clk and carries the bit that was shifted in 16 serial clocks earlier. In a chain of two devices, a command followed by one no-op writes only the second device.
- R6: Address 15 data bit 0 sets or clears test_mode, and data bits 7..1 are ignored. While test_mode is 1, digit and control registers keep their contents and accept writes. test_mode stays 1 until address 15 is loaded with bit 0 = 0.
- R7: Address 14 stores data bit 0 as ext_clk_sel and data bit 1 as soft_reset. A load with bit 1 = 1 clears every digit and control register and test_mode, while address 14 keeps the value just written.
- R8: While soft_reset is 1, loads to any address other than 14 are ignored and produce no wr_strobe. Loading address 14 with bit 1 = 0 re-enables writes.
- R9: wr_strobe is high for exactly one clk cycle for each accepted write. Address 13 is unmapped: it changes nothing and produces no wr_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Load strobe, decodes on its rising edge |
| ser_dout | output | 1 | Serial data out to the next device |
| digit_flat | output | 64 | Eight digit registers, digit 0 in the low byte |
| ctrl_flat | output | 32 | Four control registers, the first in the low byte |
| test_mode | output | 1 | Display-test override active |
| soft_reset | output | 1 | Soft-reset request held in the mode register |
| ext_clk_sel | output | 1 | External clock select held in the mode register |
| wr_strobe | output | 1 | One-cycle pulse per accepted write |

## Verification
Several rules are checked by assertions on every cycle. ser_dout moves only after a detected falling serial edge. A no-op load never raises the strobe, and every strobe follows a load. test_mode changes only on a load to address 15 or on a soft reset. While soft_reset is held, all digit and control registers stay at zero, and a load to address 14 leaves exactly the written bits in the mode register. Other behaviour can only be shown by the bench's scenarios: the field positions in the word, the 16-bit delay through a two-device chain, writes being retained and accepted during test mode, writes being refused while the soft reset is held, and the strobe count for unmapped and ignored addresses.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_NOOP = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_TEST = 4'hF;

  typedef struct packed {
    logic [3:0]        spare;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_frame_t;

  localparam int SIG_SCLK = 0;
  localparam int SIG_DIN  = 1;
  localparam int SIG_LOAD = 2;
  localparam int N_SER    = 3;
endpackage

// File: rtl/led_serial_sync.sv
module led_serial_sync #(
  parameter int N_SIG  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] async_in,
  output logic [N_SIG-1:0] sync_out,
  output logic [N_SIG-1:0] rise,
  output logic [N_SIG-1:0] fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-1:0], async_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_out[g] = chain_q[STAGES-1];
    assign rise[g]     = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall[g]     = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/led_cmd_shifter.sv
module led_cmd_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               fall_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               dout
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               dout_q, dout_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], din};
  end

  always_comb begin
    dout_d = dout_q;
    if (fall_en) dout_d = frame_q[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      dout_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      dout_q  <= dout_d;
    end
  end

  assign frame = frame_q;
  assign dout  = dout_q;

  // R5: the output bit moves only after a detected falling serial edge
  p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_en |=> $stable(dout_q));

  // R2: the frame register moves only on a detected rising serial edge
  p_shift_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(frame_q));
endmodule

// File: rtl/led_cmd_regfile.sv
module led_cmd_regfile
  import led_cmd_pkg::*;
#(
  parameter int N_DIGITS = 8,
  parameter int N_CTRL   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_evt,
  input  logic [FRAME_W-1:0]         frame,
  output logic [N_DIGITS*DATA_W-1:0] digit_flat,
  output logic [N_CTRL*DATA_W-1:0]   ctrl_flat,
  output logic                       test_mode,
  output logic                       soft_reset,
  output logic                       ext_clk_sel,
  output logic                       wr_strobe
);
  localparam int CTRL_BASE = N_DIGITS + 1;
  localparam logic [ADDR_W-1:0] DIG_LAST   = ADDR_W'(N_DIGITS);
  localparam logic [ADDR_W-1:0] CTRL_FIRST = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] CTRL_LAST  = ADDR_W'(N_DIGITS + N_CTRL);

  initial begin
    if (N_DIGITS + N_CTRL > 13) $error("address map overflow");
  end

  cmd_frame_t cmd;
  assign cmd = cmd_frame_t'(frame);

  logic [1:0] mode_q, mode_d;
  logic       test_q, test_d;
  logic       strobe_q, strobe_d;
  logic       mode_hit, clear_all, open_wr;
  logic       digit_sel, ctrl_sel, test_hit;

  assign mode_hit  = load_evt && (cmd.addr == ADDR_MODE);
  assign clear_all = mode_hit && cmd.data[1];
  assign open_wr   = load_evt && !mode_q[1];
  assign digit_sel = open_wr && (cmd.addr >= 4'd1) && (cmd.addr <= DIG_LAST);
  assign ctrl_sel  = open_wr && (cmd.addr >= CTRL_FIRST) && (cmd.addr <= CTRL_LAST);
  assign test_hit  = open_wr && (cmd.addr == ADDR_TEST);

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(g + 1);
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit;
    assign hit = open_wr && (cmd.addr == SLOT);
    always_comb begin
      val_d = val_q;
      if (clear_all) val_d = '0;
      else if (hit)  val_d = cmd.data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end
    assign digit_flat[g*DATA_W +: DATA_W] = val_q;
  end

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(CTRL_BASE + g);
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit;
    assign hit = open_wr && (cmd.addr == SLOT);
    always_comb begin
      val_d = val_q;
      if (clear_all) val_d = '0;
      else if (hit)  val_d = cmd.data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end
    assign ctrl_flat[g*DATA_W +: DATA_W] = val_q;
  end

  always_comb begin
    mode_d = mode_q;
    if (mode_hit) mode_d = cmd.data[1:0];
  end

  always_comb begin
    test_d = test_q;
    if (clear_all)     test_d = 1'b0;
    else if (test_hit) test_d = cmd.data[0];
  end

  always_comb begin
    strobe_d = mode_hit | digit_sel | ctrl_sel | test_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      test_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      test_q   <= test_d;
      strobe_q <= strobe_d;
    end
  end

  assign test_mode   = test_q;
  assign soft_reset  = mode_q[1];
  assign ext_clk_sel = mode_q[0];
  assign wr_strobe   = strobe_q;

  // R4: a no-op load never produces a strobe
  p_noop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cmd.addr == ADDR_NOOP) |=> !strobe_q);

  // R6: test bit moves only on a test-register load or a soft reset
  p_test_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && (cmd.addr == ADDR_TEST || cmd.addr == ADDR_MODE)) |=> $stable(test_q));

  // R7: the mode register keeps exactly the bits written
  p_mode_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> (mode_q == $past(cmd.data[1:0])));

  // R8: all other registers stay at default while soft reset is held
  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> (digit_flat == '0 && ctrl_flat == '0 && !test_q));

  // R9: every strobe is caused by a load in the cycle before
  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(load_evt));
endmodule

// File: rtl/led_cmd_frontend.sv
module led_cmd_frontend
  import led_cmd_pkg::*;
#(
  parameter int N_DIGITS    = 8,
  parameter int N_CTRL      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_din,
  input  logic                       ser_load,
  output logic                       ser_dout,
  output logic [N_DIGITS*DATA_W-1:0] digit_flat,
  output logic [N_CTRL*DATA_W-1:0]   ctrl_flat,
  output logic                       test_mode,
  output logic                       soft_reset,
  output logic                       ext_clk_sel,
  output logic                       wr_strobe
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_n_int;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_n_int = rst_pipe_q[1];

  logic [N_SER-1:0]   pin_vec, pin_sync, pin_rise, pin_fall;
  logic [FRAME_W-1:0] frame;

  assign pin_vec = {ser_load, ser_din, ser_clk};

  led_serial_sync #(
    .N_SIG  (N_SER),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (pin_vec),
    .sync_out (pin_sync),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  led_cmd_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (pin_rise[SIG_SCLK]),
    .fall_en  (pin_fall[SIG_SCLK]),
    .din      (pin_sync[SIG_DIN]),
    .frame    (frame),
    .dout     (ser_dout)
  );

  led_cmd_regfile #(
    .N_DIGITS (N_DIGITS),
    .N_CTRL   (N_CTRL)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load_evt    (pin_rise[SIG_LOAD]),
    .frame       (frame),
    .digit_flat  (digit_flat),
    .ctrl_flat   (ctrl_flat),
    .test_mode   (test_mode),
    .soft_reset  (soft_reset),
    .ext_clk_sel (ext_clk_sel),
    .wr_strobe   (wr_strobe)
  );
endmodule

// File: tb/led_cmd_frontend_tb_top.sv
module led_cmd_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_din, ser_load;
  logic        dout_a, dout_b;
  logic [63:0] dig_a, dig_b;
  logic [31:0] ctl_a, ctl_b;
  logic        test_a, soft_a, ext_a, stb_a;
  logic        test_b, soft_b, ext_b, stb_b;

  int errors = 0;
  int checks = 0;
  int stb_cnt = 0;
  bit done = 1'b0;

  logic [7:0] exp_dig [8];
  logic [7:0] exp_ctl [4];

  always #2 clk = ~clk;

  led_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .ser_dout(dout_a), .digit_flat(dig_a),
    .ctrl_flat(ctl_a), .test_mode(test_a), .soft_reset(soft_a),
    .ext_clk_sel(ext_a), .wr_strobe(stb_a));

  led_cmd_frontend dut2_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(dout_a),
    .ser_load(ser_load), .ser_dout(dout_b), .digit_flat(dig_b),
    .ctrl_flat(ctl_b), .test_mode(test_b), .soft_reset(soft_b),
    .ext_clk_sel(ext_b), .wr_strobe(stb_b));

  always @(posedge clk) if (stb_a === 1'b1) stb_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_dig();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_dig[i];
    return v;
  endfunction

  function automatic logic [31:0] pack_ctl();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[i*8 +: 8] = exp_ctl[i];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) begin
      ser_clk = 1'b0;
      ser_din = w[b];
      wait_clk(8);
      ser_clk = 1'b1;
      wait_clk(8);
    end
    ser_clk = 1'b0;
    wait_clk(8);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    wait_clk(8);
    ser_load = 1'b0;
    wait_clk(8);
  endtask

  task automatic write_word(input logic [3:0] junk, input logic [3:0] addr, input logic [7:0] data);
    shift_word({junk, addr, data});
    pulse_load();
  endtask

  task automatic t_reset();
    chk("R1 digits", dig_a, 64'h0);
    chk("R1 ctrl", {32'h0, ctl_a}, 64'h0);
    chk("R1 flags", {59'h0, test_a, soft_a, ext_a, stb_a, dout_a}, 64'h0);
  endtask

  task automatic t_cascade();
    int s0 = stb_cnt;
    shift_word({4'h0, 4'h3, 8'hA5});
    shift_word(16'h0000);
    pulse_load();
    chk("R5 far device digit 3", dig_b, 64'h0000_0000_00A5_0000);
    chk("R5 near device untouched", dig_a, 64'h0);
    chk("R4 no-op no strobe", 64'(stb_cnt - s0), 64'd0);
  endtask

  task automatic t_digits();
    int s0 = stb_cnt;
    for (int i = 0; i < 8; i++) begin
      exp_dig[i] = 8'(8'h11 * (i + 1)) ^ 8'h5C;
      write_word(4'hF - 4'(i), 4'(i + 1), exp_dig[i]);
    end
    chk("R2 digit registers", dig_a, pack_dig());
    chk("R9 one strobe per digit write", 64'(stb_cnt - s0), 64'd8);
  endtask

  task automatic t_ctrl();
    for (int i = 0; i < 4; i++) begin
      exp_ctl[i] = 8'(8'hC3 + 8'(i * 7));
      write_word(4'h0, 4'(9 + i), exp_ctl[i]);
    end
    chk("R3 control registers", {32'h0, ctl_a}, {32'h0, pack_ctl()});
  endtask

  task automatic t_ignored();
    int s0 = stb_cnt;
    write_word(4'h7, 4'h0, 8'hFF);
    chk("R4 no-op keeps digits", dig_a, pack_dig());
    chk("R4 no-op keeps ctrl", {32'h0, ctl_a}, {32'h0, pack_ctl()});
    write_word(4'h0, 4'hD, 8'hFF);
    chk("R9 unmapped keeps state", {ctl_a, 29'h0, test_a, soft_a, ext_a}, {pack_ctl(), 32'h0});
    chk("R9 no strobe for noop/unmapped", 64'(stb_cnt - s0), 64'd0);
  endtask

  task automatic t_test();
    write_word(4'h0, 4'hF, 8'hFE);
    chk("R6 upper bits ignored", {63'h0, test_a}, 64'd0);
    write_word(4'h0, 4'hF, 8'h01);
    chk("R6 test on", {63'h0, test_a}, 64'd1);
    chk("R6 digits retained", dig_a, pack_dig());
    exp_dig[4] = 8'h3E;
    write_word(4'h0, 4'h5, 8'h3E);
    chk("R6 write during test", dig_a, pack_dig());
    write_word(4'h0, 4'h1, 8'h00);
    exp_dig[0] = 8'h00;
    chk("R6 test persists", {63'h0, test_a}, 64'd1);
    write_word(4'h0, 4'hF, 8'hFE);
    chk("R6 test off", {63'h0, test_a}, 64'd0);
    chk("R6 ctrl retained", {32'h0, ctl_a}, {32'h0, pack_ctl()});
  endtask

  task automatic t_mode();
    int s0;
    write_word(4'h0, 4'hE, 8'h01);
    chk("R7 ext clock", {62'h0, soft_a, ext_a}, 64'd1);
    chk("R7 no clear when bit1=0", dig_a, pack_dig());
    write_word(4'h0, 4'hF, 8'h01);
    write_word(4'h0, 4'hE, 8'h03);
    chk("R7 soft reset clears digits", dig_a, 64'h0);
    chk("R7 soft reset clears ctrl/test", {31'h0, test_a, ctl_a}, 64'h0);
    chk("R7 mode kept", {62'h0, soft_a, ext_a}, 64'd3);
    s0 = stb_cnt;
    write_word(4'h0, 4'h2, 8'h77);
    write_word(4'h0, 4'hA, 8'h77);
    chk("R8 writes ignored in reset", {ctl_a, dig_a[31:0]}, 64'h0);
    chk("R8 no strobe in reset", 64'(stb_cnt - s0), 64'd0);
    write_word(4'h0, 4'hE, 8'h00);
    write_word(4'h0, 4'h2, 8'h77);
    chk("R8 writes resume", dig_a, 64'h0000_0000_0000_7700);
    chk("R7 mode cleared", {62'h0, soft_a, ext_a}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_din = 1'b0;
    ser_load = 1'b0;
    for (int i = 0; i < 8; i++) exp_dig[i] = 8'h00;
    for (int i = 0; i < 4; i++) exp_ctl[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(8);
    t_reset();
    t_cascade();
    t_digits();
    t_ctrl();
    t_ignored();
    t_test();
    t_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule